// File: doc/BRIEF.md
# Shift-Register Byte FIFO

This block is a small first-in first-out buffer for a byte stream. It holds up to sixteen bytes. The bytes sit in a single-input shift register, and there are no separate read and write pointers. Each accepted write puts the incoming byte at stage 0 and moves every byte already held one stage deeper. The oldest byte is therefore always at the stage whose index is one less than the number of bytes held. A five-bit up/down occupancy counter tracks that number and supplies the read tap address.

Reads are registered. An accepted read copies the byte at the current tap into an output register on the clock edge. That output register is a separately enabled stage behind the tap multiplexer, so the byte appears one clock after it is selected. When a write and a read land on the same edge, the read takes the tap value from before the shift. Both updates then take effect together.

The sender watches the full flag and the receiver watches the empty flag. A request that breaks a flag is ignored without side effects. A clock-enable input freezes the whole block while it is low. A synchronous reset returns the block to the empty state.

Top module: `srq_byte_fifo`

## Requirements
- R1: The occupancy stays within 0 to DEPTH (16). `fifo_empty` is high exactly when no byte is held, and `fifo_full` is high exactly when 16 bytes are held.
- R2: With `clk_en` high, `push_req` high and the buffer not full, the byte on `push_data` is stored on the rising edge and the occupancy rises by one (if no read is accepted). Bytes leave in the order they entered.
- R3: With `clk_en` high, `pop_req` high and the buffer not empty, `pop_data` takes the oldest held byte on the rising edge and the occupancy falls by one (if no write is accepted). Otherwise `pop_data` keeps its value.
- R4: When a write and a read are both accepted on one edge, the occupancy is unchanged and `pop_data` gets the oldest byte from before the shift. The new byte joins the tail of the queue.
- R5: A read request while empty is ignored: `pop_data` and the occupancy keep their values. If a write is requested on the same edge, only the write takes effect.
- R6: A write request while full is ignored: the stored bytes and the occupancy keep their values. If a read is requested on the same edge, only the read takes effect.
- R7: While `clk_en` is low, no shift, no output load and no occupancy change occur, whatever the requests are.
- R8: A high `sync_rst` at a rising edge clears the occupancy to 0 and `pop_data` to 0, whether `clk_en` is high or low. The flags then show empty and not full.
- R9: A buffer filled to all 16 bytes returns all 16 in order, including the byte read from the deepest stage (tap 15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clk_en | input | 1 | Global enable; low freezes all state |
| sync_rst | input | 1 | Synchronous reset to the empty state |
| push_data | input | 8 | Byte offered by the sender |
| push_req | input | 1 | Sender write strobe |
| fifo_full | output | 1 | High when 16 bytes are held |
| pop_data | output | 8 | Registered byte for the receiver |
| pop_req | input | 1 | Receiver read strobe |
| fifo_empty | output | 1 | High when no byte is held |

## Verification
The bound checker watches, on every cycle, the relations between a request and the next state. It confirms that the output register holds unless a read is accepted. It confirms that a disabled clock freezes the output and both flags, and that the occupancy moves by exactly one for a lone accepted write or read and stays put when both are accepted. It also confirms that an illegal request leaves the flag that forbade it unchanged, and that the two flags never rise together. Data ordering cannot be seen from the flags alone, so only the scoreboard bench can show it. The same applies to the pre-shift tap choice on a simultaneous write and read, to the deepest-stage read after a full fill, and to reset taking effect while the enable is low.

// File: rtl/srq_pkg.sv
`timescale 1ns/1ps
package srq_pkg;

   // Bits needed for an occupancy counter that spans 0..depth inclusive.
   function automatic int unsigned occ_bits(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

   // Bits needed to address one of depth shift stages.
   function automatic int unsigned tap_bits(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

   typedef enum logic [1:0] {
      OCC_HOLD = 2'd0,
      OCC_INC  = 2'd1,
      OCC_DEC  = 2'd2
   } occ_step_e;

endpackage

// File: rtl/srq_occupancy.sv
`timescale 1ns/1ps
module srq_occupancy
   import srq_pkg::*;
#(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned CNT_W  = occ_bits(DEPTH),
   parameter int unsigned ADDR_W = tap_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              clk_en,
   input  logic              sync_rst,
   input  logic              push_req,
   input  logic              pop_req,
   output logic              push_ok,
   output logic              pop_ok,
   output logic [CNT_W-1:0]  occ_cnt,
   output logic [ADDR_W-1:0] tap_addr,
   output logic              is_empty,
   output logic              is_full
);

   localparam logic [CNT_W-1:0] OCC_MAX = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] OCC_ONE = CNT_W'(1);

   logic [CNT_W-1:0] occ_q;
   logic [CNT_W-1:0] occ_less_one;
   occ_step_e        step;

   assign is_empty = (occ_q == '0);
   assign is_full  = (occ_q == OCC_MAX);

   // Requests that break a flag are dropped here and never reach the datapath.
   assign push_ok = clk_en & push_req & ~is_full;
   assign pop_ok  = clk_en & pop_req  & ~is_empty;

   always_comb begin
      unique case ({push_ok, pop_ok})
         2'b10:   step = OCC_INC;
         2'b01:   step = OCC_DEC;
         default: step = OCC_HOLD;
      endcase
   end

   always_ff @(posedge clk) begin
      if (sync_rst) begin
         occ_q <= '0;
      end else begin
         unique case (step)
            OCC_INC: occ_q <= occ_q + OCC_ONE;
            OCC_DEC: occ_q <= occ_q - OCC_ONE;
            default: occ_q <= occ_q;
         endcase
      end
   end

   // The oldest byte sits one stage below the fill level.
   assign occ_less_one = occ_q - OCC_ONE;
   assign tap_addr     = occ_less_one[ADDR_W-1:0];
   assign occ_cnt      = occ_q;

endmodule

// File: rtl/srq_shift_store.sv
`timescale 1ns/1ps
module srq_shift_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              shift_en,
   input  logic [DATA_W-1:0] shift_in,
   input  logic [ADDR_W-1:0] tap_addr,
   output logic [DATA_W-1:0] tap_data
);

   logic [DATA_W-1:0] stage_w [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : gen_stage
      logic [DATA_W-1:0] q;
      if (g == 0) begin : gen_head
         always_ff @(posedge clk) begin
            if (shift_en) q <= shift_in;
         end
      end else begin : gen_body
         always_ff @(posedge clk) begin
            if (shift_en) q <= stage_w[g-1];
         end
      end
      assign stage_w[g] = q;
   end

   // Variable tap; it reads the stage values as they stand before the edge.
   always_comb begin
      tap_data = stage_w[0];
      for (int i = 0; i < DEPTH; i++) begin
         if (tap_addr == ADDR_W'(i)) tap_data = stage_w[i];
      end
   end

endmodule

// File: rtl/srq_out_stage.sv
`timescale 1ns/1ps
module srq_out_stage #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              sync_rst,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (sync_rst)  q <= '0;
      else if (load) q <= d;
   end

endmodule

// File: rtl/srq_byte_fifo.sv
`timescale 1ns/1ps
module srq_byte_fifo
   import srq_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16
) (
   input  logic              clk,
   input  logic              clk_en,
   input  logic              sync_rst,
   input  logic [DATA_W-1:0] push_data,
   input  logic              push_req,
   output logic              fifo_full,
   output logic [DATA_W-1:0] pop_data,
   input  logic              pop_req,
   output logic              fifo_empty
);

   localparam int unsigned CNT_W  = occ_bits(DEPTH);
   localparam int unsigned ADDR_W = tap_bits(DEPTH);

   if (DEPTH < 2) begin : gen_bad_depth
      $error("srq_byte_fifo: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : gen_bad_width
      $error("srq_byte_fifo: DATA_W must be at least 1");
   end

   logic              push_ok;
   logic              pop_ok;
   logic [CNT_W-1:0]  occ_cnt;
   logic [ADDR_W-1:0] tap_addr;
   logic [DATA_W-1:0] tap_data;

   srq_occupancy #(
      .DEPTH  (DEPTH),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W)
   ) occ_i (
      .clk      (clk),
      .clk_en   (clk_en),
      .sync_rst (sync_rst),
      .push_req (push_req),
      .pop_req  (pop_req),
      .push_ok  (push_ok),
      .pop_ok   (pop_ok),
      .occ_cnt  (occ_cnt),
      .tap_addr (tap_addr),
      .is_empty (fifo_empty),
      .is_full  (fifo_full)
   );

   srq_shift_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W)
   ) store_i (
      .clk      (clk),
      .shift_en (push_ok),
      .shift_in (push_data),
      .tap_addr (tap_addr),
      .tap_data (tap_data)
   );

   srq_out_stage #(
      .DATA_W (DATA_W)
   ) out_i (
      .clk      (clk),
      .sync_rst (sync_rst),
      .load     (pop_ok),
      .d        (tap_data),
      .q        (pop_data)
   );

endmodule

// File: rtl/srq_byte_fifo_chk.sv
`timescale 1ns/1ps
module srq_byte_fifo_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned CNT_W  = 5
) (
   input logic              clk,
   input logic              clk_en,
   input logic              sync_rst,
   input logic              push_req,
   input logic              pop_req,
   input logic              fifo_full,
   input logic              fifo_empty,
   input logic [DATA_W-1:0] pop_data,
   input logic [CNT_W-1:0]  occ_cnt
);

   // R1
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (sync_rst)
      !(fifo_full && fifo_empty));

   // R1
   occ_range_chk: assert property (@(posedge clk) disable iff (sync_rst)
      occ_cnt <= CNT_W'(DEPTH));

   // R2
   push_rise_chk: assert property (@(posedge clk) disable iff (sync_rst)
      (clk_en && push_req && !pop_req && !fifo_full) |=> (occ_cnt == $past(occ_cnt) + CNT_W'(1)));

   // R3
   pop_fall_chk: assert property (@(posedge clk) disable iff (sync_rst)
      (clk_en && pop_req && !push_req && !fifo_empty) |=> (occ_cnt == $past(occ_cnt) - CNT_W'(1)));

   // R3
   out_hold_chk: assert property (@(posedge clk) disable iff (sync_rst)
      !(clk_en && pop_req && !fifo_empty) |=> $stable(pop_data));

   // R4
   both_level_chk: assert property (@(posedge clk) disable iff (sync_rst)
      (clk_en && push_req && pop_req && !fifo_empty && !fifo_full) |=> $stable(occ_cnt));

   // R5
   empty_pop_chk: assert property (@(posedge clk) disable iff (sync_rst)
      (clk_en && pop_req && !push_req && fifo_empty) |=> (fifo_empty && $stable(pop_data)));

   // R6
   full_push_chk: assert property (@(posedge clk) disable iff (sync_rst)
      (clk_en && push_req && !pop_req && fifo_full) |=> fifo_full);

   // R7
   freeze_chk: assert property (@(posedge clk) disable iff (sync_rst)
      !clk_en |=> ($stable(pop_data) && $stable(fifo_empty) && $stable(fifo_full) && $stable(occ_cnt)));

endmodule

bind srq_byte_fifo srq_byte_fifo_chk #(
   .DATA_W (DATA_W),
   .DEPTH  (DEPTH),
   .CNT_W  (CNT_W)
) chk_i (
   .clk        (clk),
   .clk_en     (clk_en),
   .sync_rst   (sync_rst),
   .push_req   (push_req),
   .pop_req    (pop_req),
   .fifo_full  (fifo_full),
   .fifo_empty (fifo_empty),
   .pop_data   (pop_data),
   .occ_cnt    (occ_cnt)
);

// File: tb/srq_byte_fifo_tb_top.sv
`timescale 1ns/1ps
module srq_byte_fifo_tb_top;

   localparam int DW    = 8;
   localparam int DEPTH = 16;

   logic          clk = 1'b0;
   logic          clk_en = 1'b0;
   logic          sync_rst = 1'b1;
   logic [DW-1:0] push_data = '0;
   logic          push_req = 1'b0;
   logic          pop_req = 1'b0;
   logic          fifo_full;
   logic          fifo_empty;
   logic [DW-1:0] pop_data;

   always #2 clk = ~clk;

   srq_byte_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
      .clk        (clk),
      .clk_en     (clk_en),
      .sync_rst   (sync_rst),
      .push_data  (push_data),
      .push_req   (push_req),
      .fifo_full  (fifo_full),
      .pop_data   (pop_data),
      .pop_req    (pop_req),
      .fifo_empty (fifo_empty)
   );

   typedef struct {
      logic [DW-1:0] data;
      bit            emp;
      bit            ful;
      string         tag;
   } exp_t;

   int            n_checks = 0;
   int            n_fail   = 0;
   bit            finished = 1'b0;
   logic [DW-1:0] model_q[$];
   logic [DW-1:0] exp_out = '0;
   exp_t          exp_q[$];

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Driver: applies one cycle of stimulus and queues the predicted outcome.
   task automatic step(input bit ce, input bit up, input bit down, input bit rst,
                       input logic [DW-1:0] d, input string tag);
      exp_t e;
      bit   can_pop;
      bit   can_push;
      @(negedge clk);
      clk_en    = ce;
      push_req  = up;
      pop_req   = down;
      sync_rst  = rst;
      push_data = d;
      if (rst) begin
         model_q.delete();
         exp_out = '0;
      end else if (ce) begin
         can_pop  = down && (model_q.size() > 0);
         can_push = up && (model_q.size() < DEPTH);
         if (can_pop)  exp_out = model_q.pop_front();
         if (can_push) model_q.push_back(d);
      end
      e.data = exp_out;
      e.emp  = (model_q.size() == 0);
      e.ful  = (model_q.size() == DEPTH);
      e.tag  = tag;
      exp_q.push_back(e);
   endtask

   // Monitor: compares the design outputs just after each edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(pop_data == e.data, e.tag, "pop_data", int'(pop_data), int'(e.data));
            check(fifo_empty == e.emp, "R1", "fifo_empty", int'(fifo_empty), int'(e.emp));
            check(fifo_full == e.ful, "R1", "fifo_full", int'(fifo_full), int'(e.ful));
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      logic [31:0] lcg = 32'h1234_5678;
      // R8: reset state
      step(1, 0, 0, 1, 8'h00, "R8");
      step(1, 0, 0, 0, 8'h00, "R8");
      // R5: read while empty is ignored
      step(1, 0, 1, 0, 8'h00, "R5");
      // R2 / R3: simple ordering
      step(1, 1, 0, 0, 8'hA1, "R2");
      step(1, 1, 0, 0, 8'hB2, "R2");
      step(1, 1, 0, 0, 8'hC3, "R2");
      step(1, 0, 1, 0, 8'h00, "R3");
      step(1, 0, 0, 0, 8'h00, "R3");
      step(1, 0, 1, 0, 8'h00, "R3");
      // R7: enable low freezes everything
      step(0, 1, 1, 0, 8'h5E, "R7");
      step(0, 0, 1, 0, 8'h00, "R7");
      // R4: simultaneous write and read with one byte held
      step(1, 1, 1, 0, 8'hD4, "R4");
      step(1, 1, 1, 0, 8'hE5, "R4");
      step(1, 1, 0, 0, 8'hF6, "R4");
      step(1, 1, 1, 0, 8'h07, "R4");
      step(1, 0, 1, 0, 8'h00, "R4");
      step(1, 0, 1, 0, 8'h00, "R4");
      // R5: write and read while empty, only the write acts
      step(1, 1, 1, 0, 8'h3C, "R5");
      step(1, 0, 1, 0, 8'h00, "R5");
      // R9: fill to sixteen
      for (int i = 0; i < DEPTH; i++) step(1, 1, 0, 0, DW'(8'h40 + i), "R9");
      // R6: write while full ignored, then both while full acts as read only
      step(1, 1, 0, 0, 8'hEE, "R6");
      step(1, 1, 1, 0, 8'hEF, "R6");
      step(1, 1, 0, 0, 8'h90, "R6");
      // R9: drain all sixteen including the deepest stage
      for (int i = 0; i < DEPTH; i++) step(1, 0, 1, 0, 8'h00, "R9");
      step(1, 0, 1, 0, 8'h00, "R5");
      // R8: reset while enable low, mid-fill
      step(1, 1, 0, 0, 8'h11, "R8");
      step(1, 1, 1, 0, 8'h22, "R8");
      step(0, 0, 0, 1, 8'h00, "R8");
      step(1, 0, 1, 0, 8'h00, "R8");
      // R2: mixed traffic, including illegal requests
      for (int i = 0; i < 400; i++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         step(lcg[31:29] != 3'd0, lcg[27], lcg[26] & lcg[25] | lcg[24] & ~lcg[27],
              1'b0, lcg[15:8], "R2");
      end
      for (int i = 0; i < DEPTH + 1; i++) step(1, 0, 1, 0, 8'h00, "R3");
      @(negedge clk);
      @(negedge clk);
      finish_run();
   end

endmodule